// File: doc/BRIEF.md
# EPROM Byte-to-Serial Bit Streamer

This block reads a byte-wide parallel EPROM one location after another and turns its contents into one continuous serial bit stream, one bit per clock. A free-running address counter drives the memory address bus. An 8-bit parallel-load shift register captures each byte and then moves it out most significant bit first. A small sequencer, running from the single block clock, decides in each cycle whether the register loads, shifts, or moves the address on.

The chip-enable and output-enable pins are held active (low) at all times, so the memory drives its data bus continuously. The address moves on one full clock before the byte at the new location is captured. This leaves a whole cycle for the memory's access time. Once the first byte has been captured, a valid strobe stays high on every cycle, and the stream runs without gaps between bytes. The address wraps to zero after its highest value, so the memory contents repeat forever.

Top module: `eprom_bit_streamer`

## Requirements
- R1: While reset is asserted, and on the clock after the reset release reaches the internal logic, the address output is 0, the serial output is 0 and the valid strobe is 0.
- R2: The chip-enable and output-enable outputs are always 0 (active low).
- R3: The first clock edge after the internal reset release captures the byte at address 0. From the next cycle on, the serial output carries that byte's bit 7 (the most significant bit).
- R4: Each captured byte appears on the serial output as bits 7, 6, ..., 0 on 8 consecutive cycles. The bit 7 of the next byte follows straight after bit 0, with no idle cycle.
- R5: The address increases by exactly one every 8 cycles. It changes on the edge that shifts out the byte's next-to-last bit position, so the new address is present for the whole cycle before its byte is captured.
- R6: The address is stable for at least one full cycle before every capture edge, and each capture takes the byte at the address presented in that cycle.
- R7: After its highest value (all ones), the address wraps to 0, and streaming continues with the byte at address 0.
- R8: The valid strobe is 0 until the first capture. After that it is 1 on every cycle until the next reset.
- R9: A value on the data input has no effect on the serial output unless it is present in the cycle just before a capture edge.
- R10: An asynchronous reset asserted in the middle of a stream clears the address, the serial output and the valid strobe at once. After release, streaming restarts from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; the address, the capture and the shift all run on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized internally |
| eprom_addr_o | output | ADDR_W (15) | Address bus to the EPROM |
| eprom_data_i | input | DATA_W (8) | Data bus from the EPROM |
| eprom_ce_n_o | output | 1 | EPROM chip enable, held low |
| eprom_oe_n_o | output | 1 | EPROM output enable, held low |
| ser_data_o | output | 1 | Serial data, most significant bit of each byte first |
| ser_vld_o | output | 1 | High while ser_data_o carries a real data bit |

## Verification
Two pairs of actions share a cycle. The address advance shares a cycle with a shift. The capture of a new byte shares a cycle with the last bit of the old byte being on the line. The address wrap from all ones to zero adds a third action to the advance cycle. The bench runs the block with a narrow address bus, so the wrap happens within a few hundred cycles. A memory model answers from the address the block presents. In one phase the model drives corrupt data in every cycle except the one before a capture. The reference model predicts the address and the serial bit for every cycle from the count of edges since reset. It flags a capture taken from the wrong address, a missing or doubled bit at a byte boundary, and any leak of the corrupt data.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  // Per-cycle control strobes issued by the sequencer
  typedef struct packed {
    logic ld;   // parallel capture of the data bus
    logic sh;   // shift the serializer one place
    logic adv;  // step the address counter
  } ebs_ctrl_t;

endpackage

// File: rtl/ebs_rst_sync.sv
module ebs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ebs_sequencer.sv
module ebs_sequencer
  import ebs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  output ebs_ctrl_t ctrl
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    ctrl.ld  = (cnt_q == '0);
    ctrl.sh  = (cnt_q != '0);
    ctrl.adv = (cnt_q == LAST);
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ebs_addr_counter.sv
module ebs_addr_counter #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (adv) addr_d = addr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;

endmodule

// File: rtl/ebs_serializer.sv
module ebs_serializer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              sh,
  input  logic [DATA_W-1:0] par_i,
  output logic              ser_o,
  output logic              vld_o
);

  logic [DATA_W-1:0] sreg_q;
  logic [DATA_W-1:0] sreg_d;
  logic              vld_q;
  logic              vld_d;

  always_comb begin
    sreg_d = sreg_q;
    vld_d  = vld_q;
    if (ld) begin
      sreg_d = par_i;
      vld_d  = 1'b1;
    end else if (sh) begin
      sreg_d = {sreg_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      vld_q  <= vld_d;
    end
  end

  assign ser_o = sreg_q[DATA_W-1];
  assign vld_o = vld_q;

endmodule

// File: rtl/eprom_bit_streamer.sv
module eprom_bit_streamer
  import ebs_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] eprom_addr_o,
  input  logic [DATA_W-1:0] eprom_data_i,
  output logic              eprom_ce_n_o,
  output logic              eprom_oe_n_o,
  output logic              ser_data_o,
  output logic              ser_vld_o
);

  logic      rst_sync_n;
  ebs_ctrl_t ctrl;

  ebs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ebs_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ctrl  (ctrl)
  );

  ebs_addr_counter #(.ADDR_W(ADDR_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .adv   (ctrl.adv),
    .addr  (eprom_addr_o)
  );

  ebs_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ld    (ctrl.ld),
    .sh    (ctrl.sh),
    .par_i (eprom_data_i),
    .ser_o (ser_data_o),
    .vld_o (ser_vld_o)
  );

  assign eprom_ce_n_o = 1'b0;
  assign eprom_oe_n_o = 1'b0;

endmodule

// File: rtl/ebs_checker.sv
module ebs_checker
  import ebs_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input ebs_ctrl_t         ctrl,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] data,
  input logic              ser,
  input logic              vld
);

  localparam int GAP_W = $clog2(DATA_W) + 2;
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(2 * DATA_W);

  logic [ADDR_W-1:0] prev_addr_q;
  logic [GAP_W-1:0]  gap_q;
  logic              seen_q;
  logic              moved;

  assign moved = (addr != prev_addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr_q <= '0;
      gap_q       <= '0;
      seen_q      <= 1'b0;
    end else begin
      prev_addr_q <= addr;
      if (moved) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (gap_q != GAP_MAX) begin
        gap_q <= gap_q + GAP_W'(1);
      end
    end
  end

  AST_ADDR_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    moved |-> (addr == prev_addr_q + ADDR_W'(1))); // R7

  AST_ADDR_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (moved && seen_q) |-> (gap_q == GAP_W'(DATA_W - 1))); // R5

  AST_ADDR_FIRST_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (moved && !seen_q) |-> (gap_q == GAP_W'(DATA_W))); // R5

  AST_ADDR_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= GAP_W'(DATA_W)); // R5

  AST_LOAD_AFTER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.adv |=> ctrl.ld); // R6

  AST_LOAD_MSB_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ld |=> (ser == $past(data[DATA_W-1]))); // R3

  AST_VLD_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ld |=> vld); // R8

  AST_VLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> vld); // R8

endmodule

bind eprom_bit_streamer ebs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ebs_checker (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .ctrl  (ctrl),
  .addr  (eprom_addr_o),
  .data  (eprom_data_i),
  .ser   (ser_data_o),
  .vld   (ser_vld_o)
);

// File: tb/test_eprom_bit_streamer.sv
module test_eprom_bit_streamer;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int WATCHDOG = 50000;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic          ce_n;
  logic          oe_n;
  logic          ser;
  logic          vld;

  int  n_checks;
  int  n_errors;
  int  edges;
  int  cycles;
  bit  corrupt;
  bit  done;

  eprom_bit_streamer #(.ADDR_W(AW), .DATA_W(DW)) i_eprom_bit_streamer (
    .clk          (clk),
    .rst_n        (rst_n),
    .eprom_addr_o (addr),
    .eprom_data_i (data),
    .eprom_ce_n_o (ce_n),
    .eprom_oe_n_o (oe_n),
    .ser_data_o   (ser),
    .ser_vld_o    (vld)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // edges seen since the last reset release (behavioural, bench only)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  function automatic logic [7:0] rom(input int a);
    return 8'(((a * 29) + 91) ^ (a >> 2) ^ (a << 5));
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  // One cycle: sample at the falling edge, compare against the model, drive memory data
  task automatic step();
    int k;
    int i;
    int byte_idx;
    int bit_pos;
    int exp_addr;
    @(negedge clk);
    k = (edges >= 2) ? edges - 2 : 0;
    chk("R2", int'(ce_n), 0, "chip enable");
    chk("R2", int'(oe_n), 0, "output enable");
    if (k == 0) begin
      chk("R1", int'(addr), 0, "address in reset state");
      chk("R1", int'(ser),  0, "serial in reset state");
      chk("R1", int'(vld),  0, "valid in reset state");
    end else begin
      i        = k - 1;
      byte_idx = (i / DW) % (1 << AW);
      bit_pos  = DW - 1 - (i % DW);
      exp_addr = (k / DW) % (1 << AW);
      chk("R8", int'(vld), 1, "valid after first capture");
      if (corrupt)
        chk("R9", int'(ser), int'(rom(byte_idx)[bit_pos]), "serial with corrupt off-capture data");
      else if (i < DW)
        chk("R3", int'(ser), int'(rom(byte_idx)[bit_pos]), "first byte serial bit");
      else if ((i / DW) >= (1 << AW))
        chk("R7", int'(ser), int'(rom(byte_idx)[bit_pos]), "serial bit after wrap");
      else
        chk("R4", int'(ser), int'(rom(byte_idx)[bit_pos]), "serial bit");
      if ((k / DW) >= (1 << AW))
        chk("R7", int'(addr), exp_addr, "address after wrap");
      else if (k % DW == 0)
        chk("R6", int'(addr), exp_addr, "address before capture");
      else
        chk("R5", int'(addr), exp_addr, "address cadence");
    end
    // the upcoming edge captures only when k is a multiple of DW
    if (corrupt && (k % DW != 0))
      data = ~rom(int'(addr)) ^ 8'h5A;
    else
      data = rom(int'(addr));
  endtask

  task automatic run(input int n);
    for (int c = 0; c < n; c++) step();
  endtask

  initial begin
    n_checks = 0;
    n_errors = 0;
    corrupt  = 1'b0;
    done     = 1'b0;
    data     = '0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state while held
    chk("R1", int'(addr), 0, "address under reset");
    chk("R1", int'(ser),  0, "serial under reset");
    chk("R1", int'(vld),  0, "valid under reset");
    data  = rom(0);
    rst_n = 1'b1;
    // run past the address wrap (64 bytes of 8 bits)
    run(700);
    // R9: garbage on the bus except in capture cycles
    corrupt = 1'b1;
    run(300);
    corrupt = 1'b0;
    // R10: asynchronous reset mid-stream, away from the clock edges
    run(5);
    #3 rst_n = 1'b0;
    #1;
    chk("R10", int'(addr), 0, "address right after async reset");
    chk("R10", int'(vld),  0, "valid right after async reset");
    chk("R10", int'(ser),  0, "serial right after async reset");
    repeat (2) @(negedge clk);
    data  = rom(0);
    rst_n = 1'b1;
    run(120);
    done = 1'b1;
    summary();
  end

  initial begin
    cycles = 0;
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_checks++;
        n_errors++;
        $display("FAIL R4 watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
        summary();
      end
    end
  end

endmodule